// File: doc/BRIEF.md
# Tagged Translation Cache with Locked Entries

This block is a small fully associative cache of address translations. Each slot holds a virtual page number, the address-space tag of the process that owns it, a frame number, a valid bit and a locked bit. A lookup arrives on a valid/ready request channel, and the address-space tag is taken from `cur_asid` in the cycle the request is accepted. One cycle later the key is compared against every slot at once. On a match the stored frame goes out on the response channel with `rsp_hit` set.

On a mismatch the block asks an external responder for the translation through a valid/ready walk channel. It takes the returned frame on a fill channel, forwards it on the response channel with `rsp_hit` clear, and installs it in the cache. An installation goes into the lowest-numbered empty slot. When no slot is empty it replaces the least recently used unlocked slot. Locked slots are never replaced and survive a flush, so several processes' translations and a set of pinned ones can live side by side.

All three channels follow the same rule. A transfer happens on a clock edge where valid and ready are both high, and a raised valid holds its data steady until that edge. Only one lookup is in flight at a time: `req_ready` is high only while the block is idle. Back-pressure on `rsp_ready` or `walk_ready` stalls the block and changes no cached state.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, both counters read zero, `req_ready` is high, and `rsp_valid` and `walk_valid` are low.
- R2: A request whose page number and captured tag match a valid slot is answered with that slot's frame and `rsp_hit`=1, with no walk issued.
- R3: A request that matches no slot raises `walk_valid` with the request's page number and captured tag. The frame accepted on the fill channel is the next response, with `rsp_hit`=0.
- R4: A fill goes to the lowest-numbered empty slot whenever one exists.
- R5: With no empty slot, a fill replaces the unlocked slot whose last hit or fill is oldest.
- R6: A pulse on `pin_req` sets the locked bit of slot `pin_idx` to `pin_val`. A locked slot is never chosen for replacement. A fill leaves its slot unlocked unless a pin to that slot lands in the same cycle.
- R7: When every slot is valid and locked, a miss still returns the fetched frame, but nothing is installed and a repeat of the same lookup misses again.
- R8: A one-cycle `flush_req` pulse empties every unlocked slot and leaves locked slots and their contents intact.
- R9: When a flush and a fill land in the same cycle, the newly installed translation survives and every other unlocked slot is emptied.
- R10: A hit requires the slot's tag to equal the tag captured with the request. The same page number may be cached under different tags at once, and each tag gets its own frame.
- R11: `hit_count` increases by one for each hit response and `miss_count` by one for each fill accepted. Both wrap at their width.
- R12: Only one lookup is outstanding at a time. A raised response or walk valid holds its data stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_asid | input | ASID_W | Tag of the running process, captured when a request is accepted |
| flush_req | input | 1 | Empty every unlocked slot |
| pin_req | input | 1 | Write the locked bit of one slot |
| pin_idx | input | IDX_W | Slot addressed by `pin_req` |
| pin_val | input | 1 | New locked bit value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pfn | output | PFN_W | Translated frame number |
| rsp_hit | output | 1 | 1 when the frame came from the cache |
| walk_valid | output | 1 | Translation fetch requested |
| walk_ready | input | 1 | Responder takes the fetch request |
| walk_vpn | output | VPN_W | Page number to fetch |
| walk_asid | output | ASID_W | Tag of the fetch |
| fill_valid | input | 1 | Fetched frame valid |
| fill_ready | output | 1 | Block waiting for the fetched frame |
| fill_pfn | input | PFN_W | Fetched frame number |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of completed misses |

## Verification
The risky pairing is a flush that lands on the same edge as a fill installs a translation. The two update the same valid bits, and the fill's slot choice was made from the pre-flush contents. The responder in the bench raises `flush_req` together with `fill_valid`, so both are taken on one edge. The result is judged only at the ports: a repeat of the just-filled lookup must hit, and a lookup installed earlier must miss. Pins that land on freshly filled slots are judged the same way, by later hits that can only succeed if the replacement skipped the locked slot.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_CMP,
    XS_WALK,
    XS_WAIT,
    XS_RESP
  } xlat_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   vpn_i  [ENTRIES],
  input  logic [ASID_W-1:0]  asid_i [ENTRIES],
  input  logic [PFN_W-1:0]   pfn_i  [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn_i,
  input  logic [ASID_W-1:0]  key_asid_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PFN_W-1:0]   hit_pfn_o
);

  logic [ENTRIES-1:0] eq;

  // one comparator per slot, all evaluated in the same cycle
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
    end
  endgenerate

  // lowest matching index wins should duplicates ever exist
  always_comb begin
    hit_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o     = |eq;
  assign hit_pfn_o = pfn_i[hit_idx_o];

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] wired_i,
  input  logic [IDX_W-1:0]   age_i [ENTRIES],
  output logic [IDX_W-1:0]   slot_o,
  output logic               ok_o
);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             lru_found;
  logic [IDX_W-1:0] lru_idx;
  logic [IDX_W-1:0] lru_age;

  // lowest-index empty slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // oldest unlocked valid slot
  always_comb begin
    lru_found = 1'b0;
    lru_idx   = '0;
    lru_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_i[i] && !wired_i[i] && (!lru_found || age_i[i] > lru_age)) begin
        lru_found = 1'b1;
        lru_idx   = IDX_W'(i);
        lru_age   = age_i[i];
      end
    end
  end

  assign ok_o   = free_found || lru_found;
  assign slot_o = free_found ? free_idx : lru_idx;

endmodule

// File: rtl/xlat_age.sv
module xlat_age #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] age_o [ENTRIES]
);

  // ages form a permutation of 0..ENTRIES-1; 0 is most recent
  logic [IDX_W-1:0] ref_age;
  assign ref_age = age_o[touch_idx_i];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          age_o[g] <= IDX_W'(g);
        end else if (touch_i) begin
          if (touch_idx_i == IDX_W'(g)) begin
            age_o[g] <= '0;
          end else if (age_o[g] < ref_age) begin
            age_o[g] <= age_o[g] + IDX_W'(1);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = idx_bits(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush_req,
  input  logic              pin_req,
  input  logic [IDX_W-1:0]  pin_idx,
  input  logic              pin_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_hit,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0] walk_asid,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [PFN_W-1:0]  fill_pfn,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  xlat_state_e       state_q;
  logic [VPN_W-1:0]  key_vpn_q;
  logic [ASID_W-1:0] key_asid_q;
  logic [PFN_W-1:0]  rsp_pfn_q;
  logic              rsp_hit_q;
  logic [CNT_W-1:0]  hit_cnt_q;
  logic [CNT_W-1:0]  miss_cnt_q;

  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_wired;
  logic [ENTRIES-1:0] valid_nx;
  logic [ENTRIES-1:0] wired_nx;
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [PFN_W-1:0] m_pfn;
  logic [IDX_W-1:0] v_slot;
  logic             v_ok;
  logic [IDX_W-1:0] ages [ENTRIES];

  logic             do_hit;
  logic             do_fill;
  logic             do_install;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  xlat_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_match (
    .valid_i   (ent_valid),
    .vpn_i     (ent_vpn),
    .asid_i    (ent_asid),
    .pfn_i     (ent_pfn),
    .key_vpn_i (key_vpn_q),
    .key_asid_i(key_asid_q),
    .hit_o     (m_hit),
    .hit_idx_o (m_idx),
    .hit_pfn_o (m_pfn)
  );

  xlat_victim #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .valid_i(ent_valid),
    .wired_i(ent_wired),
    .age_i  (ages),
    .slot_o (v_slot),
    .ok_o   (v_ok)
  );

  xlat_age #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .age_o      (ages)
  );

  assign do_hit     = (state_q == XS_CMP) && m_hit;
  assign do_fill    = (state_q == XS_WAIT) && fill_valid;
  assign do_install = do_fill && v_ok;
  assign touch      = do_hit || do_install;
  assign touch_idx  = do_hit ? m_idx : v_slot;

  assign req_ready  = (state_q == XS_IDLE);
  assign rsp_valid  = (state_q == XS_RESP);
  assign walk_valid = (state_q == XS_WALK);
  assign fill_ready = (state_q == XS_WAIT);
  assign walk_vpn   = key_vpn_q;
  assign walk_asid  = key_asid_q;
  assign rsp_pfn    = rsp_pfn_q;
  assign rsp_hit    = rsp_hit_q;
  assign hit_count  = hit_cnt_q;
  assign miss_count = miss_cnt_q;

  // request sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= XS_IDLE;
      key_vpn_q  <= '0;
      key_asid_q <= '0;
      rsp_pfn_q  <= '0;
      rsp_hit_q  <= 1'b0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (req_valid) begin
            key_vpn_q  <= req_vpn;
            key_asid_q <= cur_asid;
            state_q    <= XS_CMP;
          end
        end
        XS_CMP: begin
          if (m_hit) begin
            rsp_pfn_q <= m_pfn;
            rsp_hit_q <= 1'b1;
            hit_cnt_q <= hit_cnt_q + CNT_W'(1);
            state_q   <= XS_RESP;
          end else begin
            state_q <= XS_WALK;
          end
        end
        XS_WALK: begin
          if (walk_ready) state_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (fill_valid) begin
            rsp_pfn_q  <= fill_pfn;
            rsp_hit_q  <= 1'b0;
            miss_cnt_q <= miss_cnt_q + CNT_W'(1);
            state_q    <= XS_RESP;
          end
        end
        XS_RESP: begin
          if (rsp_ready) state_q <= XS_IDLE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  // slot flags: flush first, then the install, then a pin
  always_comb begin
    valid_nx = ent_valid;
    wired_nx = ent_wired;
    if (flush_req) valid_nx = ent_valid & ent_wired;
    if (do_install) begin
      valid_nx[v_slot] = 1'b1;
      wired_nx[v_slot] = 1'b0;
    end
    if (pin_req) wired_nx[pin_idx] = pin_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_wired <= '0;
    end else begin
      ent_valid <= valid_nx;
      ent_wired <= wired_nx;
    end
  end

  // slot payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vpn[i]  <= '0;
        ent_asid[i] <= '0;
        ent_pfn[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_install && (v_slot == IDX_W'(i))) begin
          ent_vpn[i]  <= key_vpn_q;
          ent_asid[i] <= key_asid_q;
          ent_pfn[i]  <= fill_pfn;
        end
      end
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_hit,
  input logic             walk_valid,
  input logic             walk_ready,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [PFN_W-1:0] fill_pfn,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pfn) && $stable(rsp_hit));

  // R12
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid && !walk_ready |=> walk_valid && $stable(walk_vpn));

  // R12
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R3
  fill_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> rsp_valid && !rsp_hit && (rsp_pfn == $past(fill_pfn)));

  // R2
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> !walk_valid && !fill_ready);

  // R11
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |->
      (hit_count == $past(hit_count) + CNT_W'(1)) && rsp_valid && rsp_hit);

  // R11
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |->
      (miss_count == $past(miss_count) + CNT_W'(1)) && rsp_valid && !rsp_hit);

endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_pfn   (rsp_pfn),
  .rsp_hit   (rsp_hit),
  .walk_valid(walk_valid),
  .walk_ready(walk_ready),
  .walk_vpn  (walk_vpn),
  .fill_valid(fill_valid),
  .fill_ready(fill_ready),
  .fill_pfn  (fill_pfn),
  .hit_count (hit_count),
  .miss_count(miss_count)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 12;
  localparam int ASID_W  = 4;
  localparam int PFN_W   = 10;
  localparam int CNT_W   = 8;
  localparam int IDX_W   = 2;

  logic              clk;
  logic              rst_n;
  logic [ASID_W-1:0] cur_asid;
  logic              flush_req;
  logic              pin_req;
  logic [IDX_W-1:0]  pin_idx;
  logic              pin_val;
  logic              req_valid;
  logic              req_ready;
  logic [VPN_W-1:0]  req_vpn;
  logic              rsp_valid;
  logic              rsp_ready;
  logic [PFN_W-1:0]  rsp_pfn;
  logic              rsp_hit;
  logic              walk_valid;
  logic              walk_ready;
  logic [VPN_W-1:0]  walk_vpn;
  logic [ASID_W-1:0] walk_asid;
  logic              fill_valid;
  logic              fill_ready;
  logic [PFN_W-1:0]  fill_pfn;
  logic [CNT_W-1:0]  hit_count;
  logic [CNT_W-1:0]  miss_count;

  logic flush_main;
  logic flush_fill;
  logic flush_on_fill;
  assign flush_req = flush_main | flush_fill;

  xlat_cache #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .flush_req(flush_req),
    .pin_req(pin_req), .pin_idx(pin_idx), .pin_val(pin_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pfn(rsp_pfn), .rsp_hit(rsp_hit),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vpn(walk_vpn), .walk_asid(walk_asid),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_pfn(fill_pfn),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [PFN_W-1:0] pfn;
    logic             hit;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int checks     = 0;
  int failures   = 0;
  int exp_hits   = 0;
  int exp_misses = 0;
  logic [VPN_W-1:0]  last_vpn;
  logic [ASID_W-1:0] last_asid;

  function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    return PFN_W'(32'(v) * 5 + 32'(a) * 64 + 3);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: send one lookup and queue the expected answer
  task automatic lookup(input logic [VPN_W-1:0] v, input logic exp_hit, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = v;
    while (!req_ready) @(negedge clk);
    last_vpn  = v;
    last_asid = cur_asid;
    e.pfn = pfn_of(v, cur_asid);
    e.hit = exp_hit;
    e.tag = tag;
    exp_q.push_back(e);
    if (exp_hit) exp_hits++; else exp_misses++;
    @(negedge clk);
    req_valid = 1'b0;
    wait (exp_q.size() == 0);
  endtask

  task automatic pin(input int idx, input logic val);
    @(negedge clk);
    pin_req = 1'b1;
    pin_idx = IDX_W'(idx);
    pin_val = val;
    @(negedge clk);
    pin_req = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_main = 1'b1;
    @(negedge clk);
    flush_main = 1'b0;
  endtask

  task automatic set_asid(input logic [ASID_W-1:0] a);
    @(negedge clk);
    cur_asid = a;
  endtask

  // monitor: back-pressure pattern, hold check and scoreboard compare
  initial begin
    int cyc;
    logic stalled;
    logic [PFN_W-1:0] held;
    cyc = 0;
    stalled = 1'b0;
    held = '0;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (stalled) check("R12 response held", 32'({rsp_valid, rsp_pfn}), 32'({1'b1, held}));
      cyc++;
      rsp_ready = (cyc % 3 != 0);
      stalled = rsp_valid && !rsp_ready;
      held = rsp_pfn;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R12 unexpected response", 32'(1), 32'(0));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " frame"}, 32'(rsp_pfn), 32'(e.pfn));
          check({e.tag, " hit flag"}, 32'(rsp_hit), 32'(e.hit));
        end
      end
    end
  end

  // page-table responder
  initial begin
    logic [VPN_W-1:0]  cap_v;
    logic [ASID_W-1:0] cap_a;
    walk_ready = 1'b0;
    fill_valid = 1'b0;
    fill_pfn   = '0;
    flush_fill = 1'b0;
    forever begin
      @(negedge clk);
      if (walk_valid) begin
        check("R3 walk page", 32'(walk_vpn), 32'(last_vpn));
        check("R3 walk tag", 32'(walk_asid), 32'(last_asid));
        cap_v = walk_vpn;
        cap_a = walk_asid;
        @(negedge clk);
        walk_ready = 1'b1;
        @(negedge clk);
        walk_ready = 1'b0;
        fill_valid = 1'b1;
        fill_pfn   = pfn_of(cap_v, cap_a);
        flush_fill = flush_on_fill;
        @(negedge clk);
        fill_valid = 1'b0;
        flush_fill = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cur_asid = 4'd1;
    flush_main = 1'b0;
    flush_on_fill = 1'b0;
    pin_req = 1'b0;
    pin_idx = '0;
    pin_val = 1'b0;
    req_valid = 1'b0;
    req_vpn = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", 32'(req_ready), 32'(1));
    check("R1 rsp_valid", 32'(rsp_valid), 32'(0));
    check("R1 walk_valid", 32'(walk_valid), 32'(0));
    check("R1 hit_count", 32'(hit_count), 32'(0));
    check("R1 miss_count", 32'(miss_count), 32'(0));

    // fills into an empty cache, then LRU replacement
    lookup(12'h010, 1'b0, "R1 R3 A cold");
    lookup(12'h011, 1'b0, "R3 B cold");
    lookup(12'h012, 1'b0, "R3 C cold");
    lookup(12'h013, 1'b0, "R3 D cold");
    lookup(12'h010, 1'b1, "R2 A hit");
    lookup(12'h014, 1'b0, "R5 E evicts B");
    lookup(12'h011, 1'b0, "R5 B was evicted");
    lookup(12'h010, 1'b1, "R5 A kept");
    lookup(12'h013, 1'b1, "R5 D kept");
    lookup(12'h012, 1'b0, "R5 C was evicted");
    check("R11 hit_count mid", 32'(hit_count), 32'(3));
    check("R11 miss_count mid", 32'(miss_count), 32'(7));

    // locked slot survives replacement pressure
    flush();
    lookup(12'h011, 1'b0, "R8 B after flush");
    lookup(12'h010, 1'b0, "R8 A after flush");
    lookup(12'h013, 1'b0, "R8 D after flush");
    lookup(12'h012, 1'b0, "R8 C after flush");
    pin(0, 1'b1);
    lookup(12'h015, 1'b0, "R6 F skips locked B");
    lookup(12'h016, 1'b0, "R6 G skips locked B");
    lookup(12'h011, 1'b1, "R4 R6 locked B in slot 0");
    lookup(12'h010, 1'b0, "R6 A evicted");
    lookup(12'h015, 1'b1, "R5 F kept");
    lookup(12'h016, 1'b1, "R5 G kept");

    // flush keeps the locked slot only
    flush();
    lookup(12'h011, 1'b1, "R8 locked B survives flush");
    lookup(12'h016, 1'b0, "R8 G emptied by flush");

    // tags
    set_asid(4'd2);
    lookup(12'h011, 1'b0, "R10 B under tag 2 misses");
    set_asid(4'd1);
    lookup(12'h011, 1'b1, "R10 B under tag 1 hits");
    set_asid(4'd2);
    lookup(12'h011, 1'b1, "R10 B under tag 2 hits");
    set_asid(4'd1);

    // every slot valid and locked
    lookup(12'h017, 1'b0, "R4 H into last free slot");
    pin(1, 1'b1);
    pin(2, 1'b1);
    pin(3, 1'b1);
    lookup(12'h018, 1'b0, "R7 K forwarded");
    lookup(12'h018, 1'b0, "R7 K not installed");
    lookup(12'h016, 1'b1, "R7 G kept");
    lookup(12'h017, 1'b1, "R7 H kept");
    lookup(12'h011, 1'b1, "R7 B kept");

    // flush and fill on the same edge
    pin(0, 1'b0);
    pin(1, 1'b0);
    pin(2, 1'b0);
    pin(3, 1'b0);
    flush();
    lookup(12'h020, 1'b0, "R6 R8 Q after unlock and flush");
    flush_on_fill = 1'b1;
    lookup(12'h021, 1'b0, "R9 P filled with flush");
    flush_on_fill = 1'b0;
    lookup(12'h021, 1'b1, "R9 P survives");
    lookup(12'h020, 1'b0, "R9 Q flushed");

    repeat (3) @(negedge clk);
    check("R11 hit_count final", 32'(hit_count), 32'(exp_hits));
    check("R11 miss_count final", 32'(miss_count), 32'(exp_misses));
    check("R12 idle at end", 32'({req_ready, rsp_valid, walk_valid}), 32'(3'b100));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule